// File: doc/BRIEF.md
# SDRAM Bank Precharge Timing Scheduler

This block sits between a memory controller's command sequencer and the SDRAM command pins. It takes one read, write or precharge request per cycle, decides the earliest legal cycle for each precharge, and drives the active-low row strobe, column strobe and write-enable pins together with the bank address and the A10 line. For every bank it tracks the last data beat of the access in flight. It also follows the internal auto-precharge that an access starts when its A10 bit is set.

A read releases its bank for precharge CL-1 cycles before its last output beat. A write releases its bank a write-recovery time after its last input beat. A precharge that is requested too early is parked in a one-entry holding slot and leaves on the first legal cycle, with `busy` raised while it waits. A bank with an auto-precharge still to begin refuses new commands, and those commands are parked the same way. The CAS latency is a runtime input. Values outside 2..4 raise an error flag and cause read requests to be discarded.

Top module: `precharge_sched`

## Requirements
- R1: A request accepted in cycle c appears on the pins in cycle c+1 when it is legal. Pin codes (ras_n,cas_n,we_n) are: read = 1,0,1; write = 1,0,0; precharge = 0,1,0; idle = 1,1,1. `req_op` uses 0 none, 1 read, 2 write, 3 precharge.
- R2: On a precharge, `sd_a10`=1 targets every bank and `sd_a10`=0 targets only the bank on `sd_ba`. On a read or write, `sd_a10` carries the request's auto-precharge bit. `sd_ba` always carries the request's bank field.
- R3: For a read on the pins in cycle I, `rd_last` is high in cycle I+CL+BURST-1, where CL is the `cas_lat` value at acceptance.
- R4: A precharge to a bank read in cycle I goes to the pins no earlier than CL-1 cycles before that read's last beat, which is cycle I+BURST. A precharge requested earlier is issued in exactly that cycle.
- R5: For a write on the pins in cycle I, `wr_last` is high in cycle I+BURST-1. A precharge to that bank is issued no earlier than T_WR cycles after that beat.
- R6: A request that cannot issue is held. `busy` is high from the cycle after it is accepted up to the cycle before it reaches the pins. While `busy` is high the pins stay idle and new requests have no effect.
- R7: A read with A10 set pulses `ap_start[bank]` in cycle I+BURST. A write with A10 set pulses it in cycle I+BURST-1+T_WR.
- R8: While a bank's auto-precharge has not begun, any request to that bank is held. It reaches the pins in the cycle after the `ap_start` pulse.
- R9: A precharge-all waits until every bank satisfies its own earliest-precharge limit.
- R10: When `cas_lat` is outside 2..4, `cl_err` is high in the next cycle and a read accepted in that cycle is discarded with the pins left idle. Writes still issue.
- R11: The limits are per bank. A precharge to an idle bank issues in the next cycle while another bank is busy.
- R12: After reset the pins are idle and `busy`, `cl_err`, `rd_last`, `wr_last` and `ap_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_lat | input | 3 | Runtime CAS latency, legal 2..4 |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 none, 1 read, 2 write, 3 precharge |
| req_bank | input | BA_W | Target bank |
| req_a10 | input | 1 | Auto-precharge (read/write) or all-bank (precharge) |
| busy | output | 1 | A request is held; new requests ignored |
| cl_err | output | 1 | Previous cycle's CAS latency was illegal |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address pins |
| sd_a10 | output | 1 | Address bit 10 pin |
| rd_last | output | 1 | Last read data beat on the bus |
| wr_last | output | 1 | Last write data beat on the bus |
| ap_start | output | 2**BA_W | Per-bank internal auto-precharge start pulse |

## Verification
The hardest situation to reach is a request that waits on a pending auto-precharge, because it has to arrive during the few cycles between the auto-precharge access and the start pulse. The stimulus sends the follow-on request to the same bank in the very next cycle, so it lands while the bank's pending flag is set. A precharge-all is placed behind a read on one bank and a later write on another. This way the write-recovery limit, not the read limit, decides the issue cycle. Every CAS latency value is swept so that the last-beat position moves while the precharge slot stays CL-1 cycles ahead of it.

// File: rtl/prech_pkg.sv
package prech_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_PRE   = 2'd3
  } op_e;

  localparam int CL_LO = 2;
  localparam int CL_HI = 4;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] PINS_IDLE  = 3'b111;
  localparam logic [2:0] PINS_READ  = 3'b101;
  localparam logic [2:0] PINS_WRITE = 3'b100;
  localparam logic [2:0] PINS_PRE   = 3'b010;

  function automatic logic [2:0] pins_for(op_e op);
    case (op)
      OP_READ:  return PINS_READ;
      OP_WRITE: return PINS_WRITE;
      OP_PRE:   return PINS_PRE;
      default:  return PINS_IDLE;
    endcase
  endfunction

  function automatic logic cl_legal(logic [2:0] cl);
    return (cl >= 3'(CL_LO)) && (cl <= 3'(CL_HI));
  endfunction

endpackage

// File: rtl/pc_bank_timer.sv
module pc_bank_timer #(
  parameter int BURST = 4,
  parameter int T_WR  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_wr,
  input  logic load_auto,
  output logic pre_ok,
  output logic ap_pend,
  output logic ap_start
);
  localparam int RD_HOLD = BURST - 1;
  localparam int WR_HOLD = BURST + T_WR - 2;
  localparam int MAX_HOLD = (RD_HOLD > WR_HOLD) ? RD_HOLD : WR_HOLD;
  localparam int CW = (MAX_HOLD < 1) ? 1 : $clog2(MAX_HOLD + 1);

  logic [CW-1:0] cnt, cnt_dec, load_val;

  always_comb begin
    cnt_dec  = (cnt != '0) ? cnt - CW'(1) : '0;
    load_val = load_wr ? CW'(WR_HOLD) : CW'(RD_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      ap_pend  <= 1'b0;
      ap_start <= 1'b0;
    end else begin
      ap_start <= 1'b0;
      if (load) begin
        cnt     <= (load_val > cnt_dec) ? load_val : cnt_dec;
        ap_pend <= load_auto;
      end else begin
        cnt <= cnt_dec;
        if (ap_pend && cnt == '0) begin
          ap_pend  <= 1'b0;
          ap_start <= 1'b1;
        end
      end
    end
  end

  assign pre_ok = (cnt == '0) && !ap_pend;

  // R7
  ap_clears_pend_chk: assert property (@(posedge clk) disable iff (rst)
    ap_start |-> !ap_pend);

  // R8
  pend_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (ap_pend && cnt != '0) |=> ap_pend);

endmodule

// File: rtl/pc_beat_track.sv
module pc_beat_track
  import prech_pkg::*;
#(
  parameter int BURST = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_go,
  input  logic       wr_go,
  input  logic [2:0] cas_lat,
  output logic       rd_last,
  output logic       wr_last
);
  localparam int RD_LEN = CL_HI + BURST;
  localparam int WR_LEN = BURST;

  logic [RD_LEN-1:0] rd_pipe, rd_n;
  logic [WR_LEN-1:0] wr_pipe, wr_n;

  always_comb begin
    rd_n = rd_pipe >> 1;
    if (rd_go) begin
      for (int j = 0; j < RD_LEN; j++) begin
        if (j == int'(cas_lat) + BURST - 1) rd_n[j] = 1'b1;
      end
    end
    wr_n = wr_pipe >> 1;
    if (wr_go) wr_n[WR_LEN-1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pipe <= '0;
      wr_pipe <= '0;
    end else begin
      rd_pipe <= rd_n;
      wr_pipe <= wr_n;
    end
  end

  assign rd_last = rd_pipe[0];
  assign wr_last = wr_pipe[0];

  // R10
  rd_cl_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> cl_legal(cas_lat));

endmodule

// File: rtl/precharge_sched.sv
module precharge_sched
  import prech_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int BURST = 4,
  parameter int T_WR  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           cas_lat,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic [BA_W-1:0]      req_bank,
  input  logic                 req_a10,
  output logic                 busy,
  output logic                 cl_err,
  output logic                 sd_ras_n,
  output logic                 sd_cas_n,
  output logic                 sd_we_n,
  output logic [BA_W-1:0]      sd_ba,
  output logic                 sd_a10,
  output logic                 rd_last,
  output logic                 wr_last,
  output logic [(1<<BA_W)-1:0] ap_start
);
  localparam int NB = 1 << BA_W;

  typedef struct packed {
    op_e             op;
    logic [BA_W-1:0] bank;
    logic            a10;
  } req_t;

  req_t in_req, hold_q, cand;
  logic hold_v;
  logic [NB-1:0] pre_ok, ap_pend, bank_load;
  logic cl_ok, cand_v, drop, legal, issue, stall, rw_op;

  assign in_req = '{op: op_e'(req_op), bank: req_bank, a10: req_a10};

  always_comb begin
    cl_ok  = cl_legal(cas_lat);
    cand   = hold_v ? hold_q : in_req;
    cand_v = (hold_v || req_valid) && (cand.op != OP_NONE);
    rw_op  = (cand.op == OP_READ) || (cand.op == OP_WRITE);
    drop   = (cand.op == OP_READ) && !cl_ok;
    case (cand.op)
      OP_READ, OP_WRITE: legal = !ap_pend[cand.bank];
      OP_PRE:            legal = cand.a10 ? (&pre_ok) : pre_ok[cand.bank];
      default:           legal = 1'b0;
    endcase
    issue = cand_v && !drop && legal;
    stall = cand_v && !drop && !legal;
  end

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bank
      assign bank_load[b] = issue && rw_op && (cand.bank == BA_W'(b));
      pc_bank_timer #(.BURST(BURST), .T_WR(T_WR)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (bank_load[b]),
        .load_wr  (cand.op == OP_WRITE),
        .load_auto(cand.a10),
        .pre_ok   (pre_ok[b]),
        .ap_pend  (ap_pend[b]),
        .ap_start (ap_start[b])
      );
    end
  endgenerate

  pc_beat_track #(.BURST(BURST)) i_beats (
    .clk    (clk),
    .rst    (rst),
    .rd_go  (issue && cand.op == OP_READ),
    .wr_go  (issue && cand.op == OP_WRITE),
    .cas_lat(cas_lat),
    .rd_last(rd_last),
    .wr_last(wr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v                         <= 1'b0;
      hold_q                         <= '0;
      cl_err                         <= 1'b0;
      {sd_ras_n, sd_cas_n, sd_we_n}  <= PINS_IDLE;
      sd_ba                          <= '0;
      sd_a10                         <= 1'b0;
    end else begin
      hold_v <= stall;
      if (stall) hold_q <= cand;
      cl_err <= !cl_ok;
      if (issue) begin
        {sd_ras_n, sd_cas_n, sd_we_n} <= pins_for(cand.op);
        sd_ba  <= cand.bank;
        sd_a10 <= cand.a10;
      end else begin
        {sd_ras_n, sd_cas_n, sd_we_n} <= PINS_IDLE;
      end
    end
  end

  assign busy = hold_v;

  // R6
  busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (sd_ras_n && sd_cas_n && sd_we_n));

  // R10
  cl_err_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    cl_err |-> !(sd_ras_n && !sd_cas_n && sd_we_n));

  // R8
  no_cmd_to_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (sd_ras_n && !sd_cas_n) |-> !(|($past(ap_pend) & (NB'(1) << sd_ba))));

  // R4
  single_pre_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (!sd_ras_n && sd_cas_n && !sd_we_n && !sd_a10)
      |-> (|($past(pre_ok) & (NB'(1) << sd_ba))));

  // R9
  all_pre_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (!sd_ras_n && sd_cas_n && !sd_we_n && sd_a10) |-> (&$past(pre_ok)));

endmodule

// File: tb/test_precharge_sched.sv
module test_precharge_sched;
  localparam int BL  = 4;
  localparam int TWR = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cas_lat = 3'd3;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [1:0] req_bank = 2'd0;
  logic       req_a10 = 1'b0;
  logic       busy, cl_err, sd_ras_n, sd_cas_n, sd_we_n, sd_a10, rd_last, wr_last;
  logic [1:0] sd_ba;
  logic [3:0] ap_start;

  precharge_sched #(.BA_W(2), .BURST(BL), .T_WR(TWR)) i_precharge_sched (
    .clk(clk), .rst(rst), .cas_lat(cas_lat), .req_valid(req_valid),
    .req_op(req_op), .req_bank(req_bank), .req_a10(req_a10),
    .busy(busy), .cl_err(cl_err), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a10(sd_a10),
    .rd_last(rd_last), .wr_last(wr_last), .ap_start(ap_start)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    cyc;
    int    kind;
    int    val;
    string tag;
  } ev_t;

  ev_t q[$];
  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int cmdv(int code, int ba, int a10);
    return (code << 3) | (ba << 1) | a10;
  endfunction

  task automatic expect_ev(int c, int k, int v, string t);
    q.push_back('{c, k, v, t});
  endtask

  task automatic check(bit ok, string t, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  function automatic string tag_of(int k);
    case (k)
      0: return "R1";
      1: return "R3";
      2: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic match(int k, int v);
    int found = -1;
    for (int i = 0; i < q.size(); i++) begin
      if (found < 0 && q[i].cyc == cyc && q[i].kind == k && q[i].val == v) found = i;
    end
    total++;
    if (found >= 0) q.delete(found);
    else begin
      bad++;
      $display("FAIL %s unexpected kind=%0d at cycle %0d: actual=%0d expected=none",
               tag_of(k), k, cyc, v);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (!(sd_ras_n && sd_cas_n && sd_we_n))
        match(0, cmdv({sd_ras_n, sd_cas_n, sd_we_n}, sd_ba, sd_a10));
      if (rd_last) match(1, 0);
      if (wr_last) match(2, 0);
      for (int b = 0; b < 4; b++) if (ap_start[b]) match(3, b);
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc <= cyc) begin
          check(1'b0, q[i].tag, $sformatf("missing kind=%0d at cycle %0d", q[i].kind, q[i].cyc),
                -1, q[i].val);
          q.delete(i);
        end
      end
    end
  end

  task automatic send(int op, int bank, int a10, output int pin_cyc);
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_bank  = 2'(bank);
    req_a10   = 1'(a10);
    pin_cyc   = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    req_op    = 2'd0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
    summary();
    $finish;
  end

  initial begin
    int i, j, k, p;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R12", "pins idle", {sd_ras_n, sd_cas_n, sd_we_n}, 7);
    check(busy == 1'b0 && cl_err == 1'b0, "R12", "busy/cl_err", {busy, cl_err}, 0);
    check(rd_last == 1'b0 && wr_last == 1'b0 && ap_start == 4'd0, "R12", "beats/ap",
          {rd_last, wr_last, ap_start}, 0);
    mon_on = 1'b1;

    // R3 R4 R6: read then early precharge, every CAS latency
    for (int cl = 2; cl <= 4; cl++) begin
      cas_lat = 3'(cl);
      @(negedge clk);
      send(1, cl - 2, 0, i);
      expect_ev(i, 0, cmdv(3'b101, cl - 2, 0), "R1");
      expect_ev(i + cl + BL - 1, 1, 0, "R3");
      send(3, cl - 2, 0, p);
      // R4: precharge lands CL-1 cycles before the last read beat
      expect_ev((i + cl + BL - 1) - (cl - 1), 0, cmdv(3'b010, cl - 2, 0), "R4");
      check(busy == 1'b1, "R6", "busy while held", busy, 1);
      req_valid = 1'b1; req_op = 2'd2; req_bank = 2'd3; req_a10 = 1'b0; // ignored (R6)
      @(negedge clk);
      req_valid = 1'b0; req_op = 2'd0;
      while (cyc < i + BL - 1) @(negedge clk);
      check(busy == 1'b1, "R6", "busy before issue", busy, 1);
      @(negedge clk);
      check(busy == 1'b0, "R6", "busy cleared at issue", busy, 0);
      idle(14);
    end

    // R5: write then early precharge
    cas_lat = 3'd3;
    send(2, 3, 0, i);
    expect_ev(i, 0, cmdv(3'b100, 3, 0), "R1");
    expect_ev(i + BL - 1, 2, 0, "R5");
    send(3, 3, 0, p);
    expect_ev(i + BL - 1 + TWR, 0, cmdv(3'b010, 3, 0), "R5");
    idle(14);

    // R7 R8: read auto-precharge, follow-on read held
    send(1, 2, 1, i);
    expect_ev(i, 0, cmdv(3'b101, 2, 1), "R2");
    expect_ev(i + 3 + BL - 1, 1, 0, "R3");
    expect_ev(i + BL, 3, 2, "R7");
    send(1, 2, 0, j);
    check(busy == 1'b1, "R8", "busy on pending bank", busy, 1);
    expect_ev(i + BL + 1, 0, cmdv(3'b101, 2, 0), "R8");
    expect_ev(i + BL + 1 + 3 + BL - 1, 1, 0, "R3");
    idle(18);

    // R7 R8: write auto-precharge, precharge to it held
    send(2, 1, 1, i);
    expect_ev(i, 0, cmdv(3'b100, 1, 1), "R2");
    expect_ev(i + BL - 1, 2, 0, "R5");
    expect_ev(i + BL - 1 + TWR, 3, 1, "R7");
    send(3, 1, 0, j);
    expect_ev(i + BL - 1 + TWR + 1, 0, cmdv(3'b010, 1, 0), "R8");
    idle(14);

    // R9: precharge-all waits for the later write bank
    send(1, 0, 0, i);
    expect_ev(i, 0, cmdv(3'b101, 0, 0), "R1");
    expect_ev(i + 3 + BL - 1, 1, 0, "R3");
    send(2, 3, 0, k);
    expect_ev(k, 0, cmdv(3'b100, 3, 0), "R1");
    expect_ev(k + BL - 1, 2, 0, "R5");
    send(3, 0, 1, p);
    expect_ev(k + BL - 1 + TWR, 0, cmdv(3'b010, 0, 1), "R9");
    idle(14);

    // R11: idle bank precharges at once while another is busy
    send(1, 0, 0, i);
    expect_ev(i, 0, cmdv(3'b101, 0, 0), "R1");
    expect_ev(i + 3 + BL - 1, 1, 0, "R3");
    send(3, 1, 0, p);
    expect_ev(p, 0, cmdv(3'b010, 1, 0), "R11");
    idle(14);

    // R10: illegal CAS latency
    cas_lat = 3'd5;
    @(negedge clk);
    check(cl_err == 1'b1, "R10", "cl_err for 5", cl_err, 1);
    send(1, 0, 0, i);
    check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R10", "read discarded",
          {sd_ras_n, sd_cas_n, sd_we_n}, 7);
    send(2, 2, 0, j);
    expect_ev(j, 0, cmdv(3'b100, 2, 0), "R10");
    expect_ev(j + BL - 1, 2, 0, "R5");
    idle(2);
    cas_lat = 3'd1;
    @(negedge clk);
    check(cl_err == 1'b1, "R10", "cl_err for 1", cl_err, 1);
    cas_lat = 3'd3;
    @(negedge clk);
    check(cl_err == 1'b0, "R10", "cl_err cleared", cl_err, 0);
    idle(20);

    mon_on = 1'b0;
    for (int n = 0; n < q.size(); n++)
      check(1'b0, q[n].tag, "never seen", -1, q[n].val);
    summary();
    $finish;
  end

endmodule